// File: doc/BRIEF.md
# Board Control Register Slave

This block is a small register slave on a plain 32-bit memory-mapped bus. Software reads a fixed build identifier and the processor clock rate from it. It drives a bank of LEDs from a writable register and reads back a bank of DIP switches. It also lets software ask for a whole-board reset by writing one key value to a dedicated offset.

The bus has an address, a write strobe with write data, and a read strobe with registered read data. A read is sampled on a rising edge, and the data appears on the read-data port after that edge. The block decodes a 64 KiB byte window, `ADDR_W` = 16 bits. Only five offsets hold anything. The switch inputs are asynchronous and pass through a synchronizer before they can be read. The reset request is a registered one-cycle pulse for an external reset controller.

Top module: `brd_ctl_regs`

## Requirements
- R1: While `rst_n` is low, and after its release until the first write or read, `led_out`, `bus_rdata` and `board_rst_req` are all zero.
- R2: A read of offset 0x0 returns the build identifier parameter `BUILD_ID`, 0x09272011 by default. Writes there change nothing.
- R3: A read of offset 0x4 returns the parameter `CLK_HZ`, the processor clock rate in hertz, 10,000,000 by default.
- R4: A write to offset 0x8 stores `bus_wdata[LED_W-1:0]` in the LED register. That register drives `led_out` from the edge that samples the write, one bit per LED, 1 meaning lit. A read of 0x8 returns it zero-extended.
- R5: A read of offset 0xC sampled at edge k returns `sw_in` as it stood at edge k-2, zero-extended, with 1 meaning the switch is on.
- R6: A write of exactly 0x0000DEAD (`RST_KEY`) to offset 0x10 sets `board_rst_req` high for exactly the one cycle after the edge that samples the write.
- R7: A write to 0x10 of any value other than the key, or a write of the key to any other offset, produces no pulse on `board_rst_req`.
- R8: A read of any offset other than 0x0, 0x4, 0x8 and 0xC returns zero. This covers 0x10, unaligned offsets and the top of the window. The whole `ADDR_W`-bit offset is compared.
- R9: Writes to the read-only offsets 0x0, 0x4 and 0xC, or to unmapped offsets, leave `led_out` and every readable value unchanged.
- R10: `bus_rdata` changes only on an edge where `bus_rd` is sampled high. It holds its last value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| sw_in | input | SW_W | Asynchronous DIP-switch levels |
| led_out | output | LED_W | LED drive, 1 = lit |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
The LED register is driven with every single-bit pattern, its complements, and all-zero and all-one values. These patterns expose stuck, swapped or truncated bits. The switch inputs are swept through all 256 values, and one read is placed a cycle too early to pin the synchronizer depth at exactly two stages. The key offset receives the exact key and values one bit away from it, and the key is also sent to the neighbouring offsets. This separates a full-word compare from a partial one and a full decode from a loose one. A sweep of every aligned offset in the low part of the window, plus unaligned and top-of-window offsets, shows that only the four readable offsets return data.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;
   // byte offsets decoded by software; their values are behaviour
   localparam logic [7:0] OFS_ID   = 8'h00;
   localparam logic [7:0] OFS_FREQ = 8'h04;
   localparam logic [7:0] OFS_LED  = 8'h08;
   localparam logic [7:0] OFS_SW   = 8'h0C;
   localparam logic [7:0] OFS_RST  = 8'h10;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_ID   = 3'd1,
      SEL_FREQ = 3'd2,
      SEL_LED  = 3'd3,
      SEL_SW   = 3'd4,
      SEL_RST  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/brd_ctl_decode.sv
module brd_ctl_decode
   import brd_ctl_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   // full-width compare: aliases of the populated offsets decode as unmapped
   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(OFS_ID))        sel = SEL_ID;
      else if (addr == ADDR_W'(OFS_FREQ)) sel = SEL_FREQ;
      else if (addr == ADDR_W'(OFS_LED))  sel = SEL_LED;
      else if (addr == ADDR_W'(OFS_SW))   sel = SEL_SW;
      else if (addr == ADDR_W'(OFS_RST))  sel = SEL_RST;
   end
endmodule

// File: rtl/brd_ctl_sync.sv
module brd_ctl_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("brd_ctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/brd_ctl_rstkey.sv
module brd_ctl_rstkey #(
   parameter int          DATA_W  = 32,
   parameter logic [31:0] RST_KEY = 32'h0000_DEAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              req
);
   localparam logic [DATA_W-1:0] KEY_W = DATA_W'(RST_KEY);

   // whole word compared; near misses do nothing
   always_ff @(posedge clk) begin
      if (!rst_n) req <= 1'b0;
      else        req <= wr_hit && (wdata == KEY_W);
   end
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
   import brd_ctl_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 32,
   parameter int          LED_W       = 8,
   parameter int          SW_W        = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [31:0] CLK_HZ      = 32'd10_000_000,
   parameter logic [31:0] BUILD_ID    = 32'h0927_2011,
   parameter logic [31:0] RST_KEY     = 32'h0000_DEAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [SW_W-1:0]   sw_in,
   output logic [LED_W-1:0]  led_out,
   output logic              board_rst_req
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("brd_ctl_regs: ADDR_W too small for the register offsets");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("brd_ctl_regs: DATA_W must hold a 32-bit word");
   end
   if (LED_W > DATA_W || SW_W > DATA_W || LED_W < 1 || SW_W < 1) begin : g_bad_io
      $error("brd_ctl_regs: LED_W and SW_W must be 1..DATA_W");
   end

   reg_sel_e          sel;
   logic [SW_W-1:0]   sw_sync;
   logic [LED_W-1:0]  led_q;
   logic [DATA_W-1:0] led_rd, sw_rd, rd_mux;

   brd_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   brd_ctl_sync #(.WIDTH(SW_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sw_in),
      .q     (sw_sync)
   );

   brd_ctl_rstkey #(.DATA_W(DATA_W), .RST_KEY(RST_KEY)) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (bus_wr && (sel == SEL_RST)),
      .wdata  (bus_wdata),
      .req    (board_rst_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                          led_q <= '0;
      else if (bus_wr && (sel == SEL_LED)) led_q <= bus_wdata[LED_W-1:0];
   end
   assign led_out = led_q;

   // zero extension of the narrow fields
   if (LED_W == DATA_W) begin : g_led_full
      assign led_rd = led_q;
   end else begin : g_led_ext
      assign led_rd = {{(DATA_W-LED_W){1'b0}}, led_q};
   end
   if (SW_W == DATA_W) begin : g_sw_full
      assign sw_rd = sw_sync;
   end else begin : g_sw_ext
      assign sw_rd = {{(DATA_W-SW_W){1'b0}}, sw_sync};
   end

   always_comb begin
      case (sel)
         SEL_ID:   rd_mux = DATA_W'(BUILD_ID);
         SEL_FREQ: rd_mux = DATA_W'(CLK_HZ);
         SEL_LED:  rd_mux = led_rd;
         SEL_SW:   rd_mux = sw_rd;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/brd_ctl_regs_chk.sv
module brd_ctl_regs_chk #(
   parameter int          ADDR_W   = 16,
   parameter int          DATA_W   = 32,
   parameter int          LED_W    = 8,
   parameter logic [31:0] CLK_HZ   = 32'd10_000_000,
   parameter logic [31:0] BUILD_ID = 32'h0927_2011,
   parameter logic [31:0] RST_KEY  = 32'h0000_DEAD
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [LED_W-1:0]  led_out,
   input logic              board_rst_req
);
   logic key_wr, led_wr, unmapped;
   assign key_wr   = bus_wr && (bus_addr == ADDR_W'(8'h10)) && (bus_wdata == DATA_W'(RST_KEY));
   assign led_wr   = bus_wr && (bus_addr == ADDR_W'(8'h08));
   assign unmapped = (bus_addr != ADDR_W'(8'h00)) && (bus_addr != ADDR_W'(8'h04)) &&
                     (bus_addr != ADDR_W'(8'h08)) && (bus_addr != ADDR_W'(8'h0C));

   assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && (bus_addr == ADDR_W'(8'h00)) |=> bus_rdata == DATA_W'(BUILD_ID));
   assert_freq_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && (bus_addr == ADDR_W'(8'h04)) |=> bus_rdata == DATA_W'(CLK_HZ));
   assert_led_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      led_wr |=> led_out == $past(bus_wdata[LED_W-1:0]));
   assert_key_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> board_rst_req);
   assert_no_stray_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      board_rst_req |-> $past(key_wr));
   assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && unmapped |=> bus_rdata == '0);
   assert_led_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !led_wr |=> $stable(led_out));
   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind brd_ctl_regs brd_ctl_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W),
   .CLK_HZ(CLK_HZ), .BUILD_ID(BUILD_ID), .RST_KEY(RST_KEY)
) u_chk (.*);

// File: tb/brd_ctl_regs_test.sv
module brd_ctl_regs_test;
   localparam int          AW    = 16;
   localparam int          DW    = 32;
   localparam int          LW    = 8;
   localparam int          SWW   = 8;
   localparam logic [31:0] FREQ  = 32'd10_000_000;
   localparam logic [31:0] IDENT = 32'h0927_2011;
   localparam logic [31:0] KEY   = 32'h0000_DEAD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_rdata;
   logic [SWW-1:0] sw_in = '0;
   logic [LW-1:0] led_out;
   logic          board_rst_req;

   int n_chk = 0, n_fail = 0, pulses = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   brd_ctl_regs #(.ADDR_W(AW), .DATA_W(DW), .LED_W(LW), .SW_W(SWW),
                  .CLK_HZ(FREQ), .BUILD_ID(IDENT), .RST_KEY(KEY)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .sw_in(sw_in), .led_out(led_out), .board_rst_req(board_rst_req));

   always @(posedge clk) if (rst_n && board_rst_req) pulses++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // tasks are entered and left at a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [LW-1:0] led,
                                             input logic [SWW-1:0] sw);
      case (a)
         16'h0000: return IDENT;
         16'h0004: return FREQ;
         16'h0008: return 32'(led);
         16'h000C: return 32'(sw);
         default:  return 32'h0;
      endcase
   endfunction

   initial begin
      logic [DW-1:0] v;
      logic [LW-1:0] led_model;
      int p0;
      led_model = '0;
      repeat (3) @(negedge clk);
      chk("R1 led in reset", 32'(led_out), 32'h0);
      chk("R1 req in reset", 32'(board_rst_req), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 led after reset", 32'(led_out), 32'h0);
      chk("R1 rdata after reset", bus_rdata, 32'h0);
      chk("R1 req after reset", 32'(board_rst_req), 32'h0);

      rd(16'h0000, v); chk("R2 build id", v, IDENT);
      rd(16'h0004, v); chk("R3 clock rate", v, FREQ);
      repeat (2) @(negedge clk);
      chk("R10 rdata held while idle", bus_rdata, FREQ);

      // R4: walking ones, complements, extremes
      for (int i = 0; i < LW; i++) begin
         for (int c = 0; c < 2; c++) begin
            logic [LW-1:0] pat;
            pat = (c == 0) ? LW'(1) << i : ~(LW'(1) << i);
            wr(16'h0008, {24'hA5A5A5, pat});
            led_model = pat;
            chk("R4 led drive", 32'(led_out), 32'(pat));
            rd(16'h0008, v);
            chk("R4 led readback", v, 32'(pat));
         end
      end
      wr(16'h0008, 32'hFFFF_FFFF); led_model = '1;
      chk("R4 led all on", 32'(led_out), 32'hFF);
      wr(16'h0008, 32'h0); led_model = '0;
      chk("R4 led all off", 32'(led_out), 32'h0);
      wr(16'h0008, 32'h5A); led_model = 8'h5A;

      // R5: two-stage synchronizer timing
      sw_in = 8'h00; repeat (3) @(negedge clk);
      sw_in = 8'h3C; @(negedge clk);
      rd(16'h000C, v); chk("R5 switch one cycle early still old", v, 32'h0);
      rd(16'h000C, v); chk("R5 switch after two stages", v, 32'h3C);
      for (int s = 0; s < 256; s++) begin
         sw_in = SWW'(s);
         repeat (2) @(negedge clk);
         rd(16'h000C, v);
         chk("R5 switch sweep", v, 32'(s));
      end

      // R9: writes to read-only and unmapped offsets
      wr(16'h0000, 32'h1234_5678);
      wr(16'h0004, 32'h0);
      wr(16'h000C, 32'hFFFF_FFFF);
      wr(16'h0009, 32'h0000_00FF);
      wr(16'hFFF8, 32'h0000_00FF);
      wr(16'h0108, 32'h0000_00FF);
      chk("R9 led untouched", 32'(led_out), 32'(led_model));
      rd(16'h0000, v); chk("R9 id untouched", v, IDENT);
      rd(16'h0004, v); chk("R9 rate untouched", v, FREQ);
      rd(16'h0008, v); chk("R9 led readback untouched", v, 32'(led_model));

      // R8: offset sweep over low window plus strays
      for (int a = 0; a < 128; a++) begin
         rd(AW'(a), v);
         chk("R8 offset sweep", v, exp_read(AW'(a), led_model, sw_in));
      end
      rd(16'hFFFC, v); chk("R8 top of window", v, 32'h0);
      rd(16'h1000, v); chk("R8 alias of id", v, 32'h0);
      rd(16'h0010, v); chk("R8 key offset reads zero", v, 32'h0);

      // R6: exact key
      p0 = pulses;
      wr(16'h0010, KEY);
      chk("R6 pulse high after key", 32'(board_rst_req), 32'h1);
      @(negedge clk);
      chk("R6 pulse one cycle only", 32'(board_rst_req), 32'h0);
      chk("R6 pulse count", 32'(pulses - p0), 32'h1);

      // R7: near misses and wrong offsets
      p0 = pulses;
      wr(16'h0010, 32'h0000_DEAC);
      wr(16'h0010, 32'h0001_DEAD);
      wr(16'h0010, 32'h8000_DEAD);
      wr(16'h0010, 32'h0000_5EAD);
      wr(16'h0010, 32'h0);
      wr(16'h0014, KEY);
      wr(16'h000C, KEY);
      wr(16'h0011, KEY);
      wr(16'h8010, KEY);
      @(negedge clk);
      chk("R7 no pulse from misses", 32'(pulses - p0), 32'h0);
      chk("R7 req low", 32'(board_rst_req), 32'h0);
      chk("R7 led untouched by key elsewhere", 32'(led_out), 32'(led_model));

      // R6 again: back-to-back keys
      p0 = pulses;
      wr(16'h0010, KEY);
      wr(16'h0010, KEY);
      @(negedge clk);
      chk("R6 two keys two pulses", 32'(pulses - p0), 32'h2);

      // R10: a write does not disturb read data
      rd(16'h0000, v);
      wr(16'h0008, 32'h0F);
      chk("R10 rdata held across write", bus_rdata, IDENT);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule